// File: doc/BRIEF.md
# Producer-Consumer Row Reservoir Synchronizer

This block keeps one producer and one consumer in step while they share a circular buffer of feature-map rows. It keeps a count of the rows that are present: rows the producer has written and the consumer has not yet retired. From that count it decides two things each cycle. It decides whether the consumer may start its next fetch, and whether the producer must hold back so it does not overwrite rows the consumer still needs. The memory array and the address generators inside each core are outside this block. It only exchanges per-row pulses and stall/grant levels with them.

In the normal streaming mode, the consumer is granted a step as soon as the stored rows cover its configured window. The two sides then run at the same time while the count stays between that window and the configured buffer depth. After each step the consumer retires a configurable stride of rows, so overlapping windows keep their shared rows. When the producer signals the end of a frame, the consumer may drain whatever partial window is left. The producer then stays held until the buffer is empty, and the frame state clears. A step-lock mode withholds every grant until the whole frame is in the buffer. This spends buffer space to keep the handoff simple.

Top module: `row_reservoir_sync`

## Requirements
- R1: After reset the buffer is empty and no frame end is pending: `prodStall` is 0, and `consGrant` is 0 even while `consReq` is 1 (with `cfgWindow` of at least 1).
- R2: In streaming mode, with no frame end pending, `consGrant` is 1 exactly when `consReq` is 1 and the stored row count is at least `cfgWindow`.
- R3: When the stored row count equals `cfgDepth`, `prodStall` is 1. A `prodRowDone` pulse during a stall adds no row.
- R4: A `consRelease` pulse removes `cfgStride` rows, or every stored row if fewer are present. A release on an empty buffer has no effect.
- R5: A row write and a release in the same cycle both take effect. The new count is old + 1 − released.
- R6: After a `prodFrameDone` pulse, the consumer is granted whenever it requests and at least one row is stored, even below `cfgWindow`. The producer is stalled while that frame drains.
- R7: Once a finished frame has fully drained (count 0), the frame-end state clears in the next cycle, and `prodStall` drops one cycle after the count reaches zero.
- R8: With `cfgStepLock` = 1, no grant is issued before `prodFrameDone`. The producer is stalled only by a full buffer until then.
- R9: `consGrant` is never 1 while `consReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDepth | input | CNT_W | Buffer capacity in rows |
| cfgWindow | input | CNT_W | Rows needed for one consumer step (at least 1) |
| cfgStride | input | CNT_W | Rows retired by one release (at least 1) |
| cfgStepLock | input | 1 | 1 = whole-frame handoff, 0 = streaming |
| prodRowDone | input | 1 | Producer finished writing one row |
| prodFrameDone | input | 1 | Producer finished the frame |
| prodStall | output | 1 | Producer must not write another row |
| consReq | input | 1 | Consumer asks to start a fetch step |
| consRelease | input | 1 | Consumer finished a step, retire its stride |
| consGrant | output | 1 | Consumer fetch may proceed |

## Verification
The bench builds the block with a 4-bit counter width, so a depth of a few rows is easy to fill. Stall-while-full, clamped releases and simultaneous write/release occur often under random traffic at that width. It runs streaming configurations with stride smaller than, equal to and larger than the window, plus a step-lock configuration, with a rare frame-end pulse. These bring partial-window drains and the frame-state clear into reach many times per run.

// File: rtl/row_reservoir_pkg.sv
package row_reservoir_pkg;
  typedef struct packed {
    logic wrAccept;
    logic relAccept;
    logic setEnd;
    logic clrEnd;
  } resStrobe_t;
endpackage

// File: rtl/row_reservoir_dp.sv
module row_reservoir_dp
  import row_reservoir_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgStride,
  input  resStrobe_t       strobe,
  output logic [CNT_W-1:0] occ,
  output logic             frameEnded
);
  localparam logic [CNT_W-1:0] ONE_ROW = CNT_W'(1);

  logic [CNT_W-1:0] relAmt;
  logic [CNT_W-1:0] occNext;

  always_comb begin
    relAmt  = (cfgStride < occ) ? cfgStride : occ;
    occNext = occ + (strobe.wrAccept ? ONE_ROW : '0) - (strobe.relAccept ? relAmt : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ        <= '0;
      frameEnded <= 1'b0;
    end else begin
      occ <= occNext;
      if (strobe.clrEnd)      frameEnded <= 1'b0;
      else if (strobe.setEnd) frameEnded <= 1'b1;
    end
  end

  // R5: a write alone adds exactly one row
  p_write_adds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrAccept && !strobe.relAccept) |=> (occ == $past(occ) + ONE_ROW));

  // R4: a release on a non-empty buffer with no write shrinks the count
  p_release_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.relAccept && !strobe.wrAccept && cfgStride != '0) |=> (occ < $past(occ)));
endmodule

// File: rtl/row_reservoir_ctrl.sv
module row_reservoir_ctrl
  import row_reservoir_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgDepth,
  input  logic [CNT_W-1:0] cfgWindow,
  input  logic             cfgStepLock,
  input  logic             prodRowDone,
  input  logic             prodFrameDone,
  input  logic             consReq,
  input  logic             consRelease,
  input  logic [CNT_W-1:0] occ,
  input  logic             frameEnded,
  output logic             prodStall,
  output logic             consGrant,
  output resStrobe_t       strobe
);
  logic bufFull;
  logic haveWindow;
  logic canDrain;

  always_comb begin
    bufFull    = (occ >= cfgDepth);
    haveWindow = !cfgStepLock && (occ >= cfgWindow);
    canDrain   = frameEnded && (occ != '0);
    prodStall  = bufFull || frameEnded;
    consGrant  = consReq && (haveWindow || canDrain);

    strobe.wrAccept  = prodRowDone && !prodStall;
    strobe.relAccept = consRelease && (occ != '0);
    strobe.setEnd    = prodFrameDone && !frameEnded;
    strobe.clrEnd    = frameEnded && (occ == '0);
  end

  // R3: a stalled producer cannot raise the count
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (prodStall && !consRelease) |=> (occ == $past(occ)));

  // R7: a drained frame clears its end state on the next edge
  p_drain_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnded && occ == '0) |=> !frameEnded);

  // R8: step-lock issues nothing before the frame is complete
  p_steplock_waits_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStepLock && !frameEnded) |-> !consGrant);

  // R9: no grant without a request
  p_grant_needs_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    !consReq |-> !consGrant);
endmodule

// File: rtl/row_reservoir_sync.sv
module row_reservoir_sync
  import row_reservoir_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgDepth,
  input  logic [CNT_W-1:0] cfgWindow,
  input  logic [CNT_W-1:0] cfgStride,
  input  logic             cfgStepLock,
  input  logic             prodRowDone,
  input  logic             prodFrameDone,
  output logic             prodStall,
  input  logic             consReq,
  input  logic             consRelease,
  output logic             consGrant
);
  resStrobe_t       strobe;
  logic [CNT_W-1:0] occ;
  logic             frameEnded;

  row_reservoir_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgDepth(cfgDepth), .cfgWindow(cfgWindow), .cfgStepLock(cfgStepLock),
    .prodRowDone(prodRowDone), .prodFrameDone(prodFrameDone),
    .consReq(consReq), .consRelease(consRelease),
    .occ(occ), .frameEnded(frameEnded),
    .prodStall(prodStall), .consGrant(consGrant), .strobe(strobe)
  );

  row_reservoir_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfgStride(cfgStride), .strobe(strobe),
    .occ(occ), .frameEnded(frameEnded)
  );
endmodule

// File: tb/row_reservoir_sync_tb.sv
module row_reservoir_sync_tb_top;
  localparam int CNT_W = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rstN;
  logic [CNT_W-1:0] cfgDepth, cfgWindow, cfgStride;
  logic cfgStepLock;
  logic prodRowDone, prodFrameDone, consReq, consRelease;
  logic prodStall, consGrant;

  int total = 0;
  int bad = 0;
  int mOcc = 0;
  bit mEnd = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_reservoir_sync #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .cfgDepth(cfgDepth), .cfgWindow(cfgWindow), .cfgStride(cfgStride),
    .cfgStepLock(cfgStepLock),
    .prodRowDone(prodRowDone), .prodFrameDone(prodFrameDone), .prodStall(prodStall),
    .consReq(consReq), .consRelease(consRelease), .consGrant(consGrant)
  );

  function automatic bit expStallF();
    return (mOcc >= int'(cfgDepth)) || mEnd;
  endfunction

  function automatic bit expGrantF(input bit rq);
    return rq && ((!cfgStepLock && mOcc >= int'(cfgWindow)) || (mEnd && mOcc != 0));
  endfunction

  function automatic string stallTag();
    if (mEnd) return "R6";
    if (mOcc >= int'(cfgDepth)) return "R3";
    return cfgStepLock ? "R8" : "R2";
  endfunction

  function automatic string grantTag(input bit rq);
    if (!rq) return "R9";
    if (mEnd) return "R6";
    return cfgStepLock ? "R8" : "R2";
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (occ model=%0d)", tag, what, act, exp, mOcc);
    end
  endtask

  // one cycle: drive, check outputs mid-cycle, advance model to the next edge
  task automatic step(input bit rd, input bit fd, input bit rq, input bit rl, input string phase);
    bit eStall, eGrant, wr, rel;
    int amt;
    @(negedge clk);
    prodRowDone = rd; prodFrameDone = fd; consReq = rq; consRelease = rl;
    #1;
    eStall = expStallF();
    eGrant = expGrantF(rq);
    check({stallTag(), " ", phase}, "prodStall", prodStall, eStall);
    check({grantTag(rq), " ", phase}, "consGrant", consGrant, eGrant);
    wr  = rd && !eStall;
    rel = rl && (mOcc != 0);
    amt = (int'(cfgStride) < mOcc) ? int'(cfgStride) : mOcc;
    if (mEnd && mOcc == 0) mEnd = 0;
    else if (fd && !mEnd)  mEnd = 1;
    mOcc = mOcc + (wr ? 1 : 0) - (rel ? amt : 0);
  endtask

  task automatic configure(input int d, input int w, input int s, input bit sl);
    @(negedge clk);
    rstN = 1'b0;
    cfgDepth = CNT_W'(d); cfgWindow = CNT_W'(w); cfgStride = CNT_W'(s); cfgStepLock = sl;
    prodRowDone = 0; prodFrameDone = 0; consReq = 0; consRelease = 0;
    @(negedge clk);
    rstN = 1'b1;
    mOcc = 0; mEnd = 0;
  endtask

  task automatic randomRun(input int cycles, input int pWr, input int pRel, input int pEnd);
    for (int i = 0; i < cycles; i++) begin
      bit rq;
      rq = ($urandom % 100) < 70;
      step(($urandom % 100) < pWr, ($urandom % 1000) < pEnd, rq,
           rq && (($urandom % 100) < pRel), "rand");
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed_0314);
    rstN = 1'b0;
    configure(4, 2, 1, 0);
    // R1: reset state with a pending request
    step(0, 0, 1, 0, "R1");
    // R2: window threshold
    step(1, 0, 1, 0, "R2");
    step(0, 0, 1, 0, "R2");           // one row: no grant
    step(1, 0, 1, 0, "R2");           // second row written this cycle
    step(0, 0, 1, 0, "R2");           // two rows: grant
    // R3: fill to depth, extra writes ignored
    step(1, 0, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");           // stalled, dropped
    step(1, 0, 0, 0, "R3");
    // R5: release and write together: 4 -> 3 (write blocked as full)
    step(1, 0, 1, 1, "R5");
    step(1, 0, 1, 1, "R5");           // 3 +1 -1 = 3
    step(0, 0, 1, 0, "R5");
    // R4: stride larger than stored rows clamps to zero
    configure(6, 3, 5, 0);
    step(1, 0, 0, 0, "R4");
    step(1, 0, 0, 0, "R4");
    step(0, 0, 1, 1, "R4");           // releases 2, not 5
    step(0, 0, 1, 1, "R4");           // empty release ignored
    step(1, 0, 1, 0, "R4");
    step(1, 0, 1, 0, "R4");
    step(1, 0, 1, 0, "R4");
    step(0, 0, 1, 0, "R4");           // three rows: grant
    // R6/R7: frame end with a partial window, then drain
    step(0, 1, 1, 0, "R6");
    step(1, 0, 1, 1, "R6");
    step(0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, "R7");
    // R8: step-lock holds grants until the frame ends
    configure(8, 2, 2, 1);
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, "R8");
    step(0, 1, 1, 0, "R8");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, "R8");
    // R9: no request, no grant
    configure(5, 1, 1, 0);
    step(1, 0, 0, 0, "R9");
    step(1, 0, 0, 0, "R9");
    // constrained random across configurations
    configure(6, 3, 1, 0);  randomRun(500, 60, 40, 8);
    configure(5, 2, 2, 0);  randomRun(500, 55, 50, 8);
    configure(7, 2, 4, 0);  randomRun(400, 70, 30, 10);
    configure(12, 3, 2, 1); randomRun(500, 60, 60, 12);
    configure(3, 3, 3, 0);  randomRun(300, 80, 40, 5);
    doneFlag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!doneFlag) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule